// File: doc/BRIEF.md
# Restartable Seconds Interval Timer

This block turns a fast system clock into a one-second tick and measures intervals as a whole number of those ticks. A sequencer issues a one-cycle start pulse together with a duration in seconds. The timer then counts that many ticks and raises an expired flag. Every start also zeroes the seconds prescaler. As a result, the first second of an interval is always a full second and never the remainder of a second already under way.

The prescaler keeps running when no interval is active. Its tick output can therefore pace periodic behaviour such as a blinking lamp. The interval counter is a loaded down-counter, and expiry is its terminal borrow. A duration of zero is treated as one second, so every phase the sequencer times lasts at least one tick. The divide ratio is a parameter. A bench can set it to a few cycles, and silicon sets it to the clock frequency.

Top module: `sec_interval_timer`

## Requirements
- R1: While rst_n is low, and in the first cycle after it rises, expired_o and tick_o are low (for CLKS_PER_SEC greater than 1).
- R2: With no start, tick_o is high for exactly one cycle in every CLKS_PER_SEC cycles.
- R3: After a cycle with start_i high, the next tick_o pulse appears exactly CLKS_PER_SEC cycles later. The prescaler is restarted.
- R4: For a duration D of 1 or more sampled with start_i, expired_o is first high D*CLKS_PER_SEC+1 cycles after the start cycle. That is the cycle right after the D-th tick.
- R5: A duration of 0 gives the same expiry timing as a duration of 1.
- R6: Once high, expired_o stays high until start_i is seen. In the cycle after start_i it is low.
- R7: A start issued while an interval is running abandons it. Timing then follows only the new start and its duration.
- R8: expired_o stays low in every cycle from the cycle after a start until the expiry cycle given by R4.
- R9: dur_i is sampled only in cycles where start_i is high. Changing it at other times has no effect on expiry timing.
- R10: When start_i is held high for several cycles, timing per R3 and R4 counts from the last cycle in which it was high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Restart prescaler and load a new interval |
| dur_i | input | DUR_W | Interval length in seconds, sampled with start_i |
| expired_o | output | 1 | Interval complete, held until the next start |
| tick_o | output | 1 | One-cycle pulse once per second |

## Verification
On every cycle, the assertions check four properties. Tick spacing is tied to the latest restart, and each tick lasts one cycle. The expired flag only rises on the cycle after a tick that was not itself a restart. The flag holds until a start and drops right after one. The exact expiry cycle for each duration depends on the sampled value. Its interaction with zero durations, restarts mid-count, held starts and late changes to the duration input can only be shown by the bench's scenarios against its cycle-counting reference model.

// File: rtl/sit_pkg.sv
package sit_pkg;

    typedef enum logic [1:0] {
        SIT_IDLE = 2'd0,
        SIT_RUN  = 2'd1,
        SIT_DONE = 2'd2
    } sit_state_e;

endpackage

// File: rtl/sit_prescaler.sv
module sit_prescaler #(
    parameter int DIV = 125_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart_i,
    output logic tick_o
);
    localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    typedef struct packed {
        logic [PW-1:0] cnt;
    } pre_s;

    pre_s pre_d, pre_q;

    always_comb begin
        pre_d = pre_q;
        if (restart_i || pre_q.cnt == LAST) begin
            pre_d.cnt = '0;
        end else begin
            pre_d.cnt = pre_q.cnt + PW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q <= '0;
        end else begin
            pre_q <= pre_d;
        end
    end

    assign tick_o = (pre_q.cnt == LAST);

endmodule

// File: rtl/sit_interval_cnt.sv
module sit_interval_cnt
    import sit_pkg::*;
#(
    parameter int DW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [DW-1:0] dur_i,
    input  logic          tick_i,
    output logic          expired_o
);
    typedef struct packed {
        sit_state_e    st;
        logic [DW-1:0] left;
    } ivl_s;

    ivl_s ivl_d, ivl_q;
    logic [DW:0] dec_w;

    assign dec_w = {1'b0, ivl_q.left} - (DW+1)'(1);

    always_comb begin
        ivl_d = ivl_q;
        if (load_i) begin
            ivl_d.st   = SIT_RUN;
            ivl_d.left = (dur_i == '0) ? '0 : dur_i - DW'(1);
        end else if (ivl_q.st == SIT_RUN && tick_i) begin
            if (dec_w[DW]) begin
                ivl_d.st   = SIT_DONE;
                ivl_d.left = '0;
            end else begin
                ivl_d.left = dec_w[DW-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ivl_q.st   <= SIT_IDLE;
            ivl_q.left <= '0;
        end else begin
            ivl_q <= ivl_d;
        end
    end

    assign expired_o = (ivl_q.st == SIT_DONE);

endmodule

// File: rtl/sec_interval_timer.sv
module sec_interval_timer #(
    parameter int CLKS_PER_SEC = 125_000_000,
    parameter int DUR_W        = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [DUR_W-1:0] dur_i,
    output logic             expired_o,
    output logic             tick_o
);
    logic sec_tick;

    sit_prescaler #(
        .DIV(CLKS_PER_SEC)
    ) u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart_i(start_i),
        .tick_o   (sec_tick)
    );

    sit_interval_cnt #(
        .DW(DUR_W)
    ) u_ivl (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (start_i),
        .dur_i    (dur_i),
        .tick_i   (sec_tick),
        .expired_o(expired_o)
    );

    assign tick_o = sec_tick;

endmodule

// File: rtl/sit_checker.sv
module sit_checker #(
    parameter int DIV = 125_000_000
) (
    input logic clk,
    input logic rst_n,
    input logic start_i,
    input logic expired_o,
    input logic tick_o
);
    int unsigned gap_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap_q <= 0;
        end else if (start_i || tick_o) begin
            gap_q <= 0;
        end else begin
            gap_q <= gap_q + 1;
        end
    end

    AST_TICK_ON_SCHEDULE: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |-> (gap_q == DIV - 1)); // R3

    AST_TICK_DUE: assert property (@(posedge clk) disable iff (!rst_n)
        (gap_q == DIV - 1) |-> tick_o); // R2

    generate
        if (DIV > 1) begin : g_narrow
            AST_TICK_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
                tick_o |=> !tick_o); // R2
        end
    endgenerate

    AST_EXPIRE_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(expired_o) |-> ($past(tick_o) && !$past(start_i))); // R4

    AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> !expired_o); // R6

    AST_EXPIRED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (expired_o && !start_i) |=> expired_o); // R6

endmodule

bind sec_interval_timer sit_checker #(.DIV(CLKS_PER_SEC)) u_sit_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .expired_o(expired_o),
    .tick_o   (tick_o)
);

// File: tb/sec_interval_timer_bench.sv
module sec_interval_timer_bench;
    localparam int N  = 5;
    localparam int DW = 4;
    localparam int WD_LIMIT = 20000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic [DW-1:0] dur_i = '0;
    logic          expired_o;
    logic          tick_o;

    int    n_checks = 0;
    int    n_fail = 0;
    int    cyc = 0;
    bit    done = 1'b0;
    string cur_req = "R1";

    // reference model state
    int m_phase = 0;
    int m_since = 0;
    int m_target = 0;
    bit m_armed = 1'b0;

    always #4 clk = ~clk;

    sec_interval_timer #(
        .CLKS_PER_SEC(N),
        .DUR_W(DW)
    ) u_sec_interval_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_i),
        .dur_i    (dur_i),
        .expired_o(expired_o),
        .tick_o   (tick_o)
    );

    always @(posedge clk) begin
        if (!rst_n) begin
            m_phase = 0;
            m_since = 0;
            m_target = 0;
            m_armed = 1'b0;
        end else begin
            if (start_i) begin
                m_phase = 0;
                m_since = 1;
                m_armed = 1'b1;
                m_target = ((dur_i == 0) ? 1 : int'(dur_i)) * N + 1;
            end else begin
                m_phase = (m_phase + 1) % N;
                if (m_armed) m_since = m_since + 1;
            end
        end
    end

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual %0b expected %0b (cycle %0d)", req, what, act, exp, cyc);
        end
    endtask

    always @(negedge clk) begin
        if (!done) begin
            chk(cur_req, "tick_o", tick_o, (m_phase == N - 1));
            chk(cur_req, "expired_o", expired_o, (m_armed && m_since >= m_target));
        end
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc >= WD_LIMIT && !done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual %0d cycles expected below %0d", cyc, WD_LIMIT);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulse_start(input logic [DW-1:0] d);
        start_i = 1'b1;
        dur_i = d;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    initial begin
        cur_req = "R1";
        step(3);
        chk("R1", "expired_o in reset", expired_o, 1'b0);
        chk("R1", "tick_o in reset", tick_o, 1'b0);
        rst_n = 1'b1;
        step(1);
        chk("R1", "expired_o after reset", expired_o, 1'b0);
        chk("R1", "tick_o after reset", tick_o, 1'b0);

        cur_req = "R2";
        step(13);

        // R3 and R4: duration 3
        cur_req = "R3";
        step(2);
        pulse_start(4'd3);
        step(N - 2);
        chk("R3", "tick_o before first second", tick_o, 1'b0);
        step(1);
        chk("R3", "tick_o at first second", tick_o, 1'b1);
        cur_req = "R4";
        step(2 * N);
        chk("R4", "expired_o one cycle early", expired_o, 1'b0);
        step(1);
        chk("R4", "expired_o on time", expired_o, 1'b1);

        // R6: hold then clear
        cur_req = "R6";
        step(20);
        chk("R6", "expired_o held", expired_o, 1'b1);
        pulse_start(4'd2);
        chk("R6", "expired_o cleared by start", expired_o, 1'b0);
        step(2 * N);
        chk("R6", "expired_o after duration 2", expired_o, 1'b1);

        // R5: zero duration
        cur_req = "R5";
        pulse_start(4'd0);
        step(N - 1);
        chk("R5", "zero duration early", expired_o, 1'b0);
        step(1);
        chk("R5", "zero duration on time", expired_o, 1'b1);

        // R7: restart mid-count with shorter duration
        cur_req = "R7";
        pulse_start(4'd6);
        step(12);
        pulse_start(4'd1);
        step(N - 1);
        chk("R7", "restart early", expired_o, 1'b0);
        step(1);
        chk("R7", "restart on time", expired_o, 1'b1);

        // R9: dur_i changes outside start
        cur_req = "R9";
        pulse_start(4'd2);
        dur_i = 4'd9;
        step(3);
        dur_i = 4'd15;
        step(2 * N - 4);
        chk("R9", "late dur change early", expired_o, 1'b0);
        step(1);
        chk("R9", "late dur change on time", expired_o, 1'b1);

        // R10: held start
        cur_req = "R10";
        start_i = 1'b1;
        dur_i = 4'd1;
        step(3);
        start_i = 1'b0;
        step(N - 1);
        chk("R10", "tick_o after held start", tick_o, 1'b1);
        chk("R10", "held start early", expired_o, 1'b0);
        step(1);
        chk("R10", "held start on time", expired_o, 1'b1);

        // R8: low throughout count
        cur_req = "R8";
        pulse_start(4'd4);
        for (int k = 1; k <= 4 * N; k++) begin
            chk("R8", "expired_o during count", expired_o, 1'b0);
            step(1);
        end
        chk("R8", "expired_o at end of count", expired_o, 1'b1);

        // R4: largest duration
        cur_req = "R4";
        pulse_start(4'd15);
        step(15 * N - 1);
        chk("R4", "max duration early", expired_o, 1'b0);
        step(1);
        chk("R4", "max duration on time", expired_o, 1'b1);
        step(5);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule